// File: doc/BRIEF.md
# Function-Coded 16-bit ALU

This block is the arithmetic core of a small single-cycle processor datapath. It is purely combinational. Two 16-bit operands and a 3-bit function code select one of six arithmetic or logic results. Two separate shift controls select a logical shift of the second operand by a 3-bit amount. The decoded controls and the operands are supplied by the surrounding datapath. The 16-bit result goes back to register write-back or to memory addressing.

A zero flag accompanies every result. The branch logic uses this flag to decide equal and not-equal comparisons, after a subtraction of the two register values. The block does not report overflow or carry. Unused function codes give a result of zero.

Top module: `alu16_core`

## Requirements
- R1: With shift disabled and function code 3'b001, the result is operand A plus operand B, taken modulo 2^16.
- R2: With shift disabled and function code 3'b011, the result is A minus B, taken modulo 2^16 in two's complement.
- R3: With shift disabled and function code 3'b010, the result is the bitwise AND of A and B.
- R4: With shift disabled and function code 3'b100, the result is the bitwise OR of A and B.
- R5: With shift disabled and function code 3'b101, the result is 16'h0001 when A is less than B as signed two's-complement numbers, and 16'h0000 otherwise.
- R6: With shift disabled and function code 3'b111, the result is the unsigned product of A[7:0] and B[7:0], a full 16-bit value. Bits A[15:8] and B[15:8] have no effect on it.
- R7: With the shift enable high and the direction input low, the result is B shifted left by the shift amount, with zeros filling the low bits. A has no effect.
- R8: With the shift enable high and the direction input high, the result is B shifted right logically by the shift amount, with zeros filling the high bits. A has no effect.
- R9: When the shift enable is high, the shift result is selected whatever the function code is.
- R10: With shift disabled, function codes 3'b000 and 3'b110 give a result of zero for any operands.
- R11: The zero flag is high exactly when all 16 result bits are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand; this is also the value that is shifted |
| func_code | input | 3 | Selects the arithmetic or logic function |
| shift_en | input | 1 | When high, the result comes from the shifter |
| shift_right | input | 1 | Shift direction: 0 shifts left, 1 shifts right |
| shift_amt | input | 3 | Shift distance in bit positions |
| result | output | 16 | Result of the selected function |
| zero_flag | output | 1 | High when the result is all zeros |

## Verification
The bench builds the block with the default parameters: a 16-bit data path, an 8-bit multiplier input and a 3-bit shift amount. With these values every shift distance from 0 to 7 can be driven in both directions, so each zero-fill boundary is reached. The largest byte product, 255 times 255, can also be reached, and with it the full 16-bit product range. Directed cases cover wrap-around at the 16-bit boundary, signed comparison across the sign bit, and upper operand bytes that must not affect the product. A batch of random operands and codes completes the checks, and every result is compared against an independent reference model.

// File: rtl/alu16_pkg.sv
// Package: alu16_pkg
// Purpose : shared function-code encoding for the 16-bit ALU.
// Assumes : the decoder drives the 3-bit code directly. Codes 000 and
//           110 carry no function.
package alu16_pkg;

    typedef enum logic [2:0] {
        FN_NONE = 3'b000,
        FN_ADD  = 3'b001,
        FN_AND  = 3'b010,
        FN_SUB  = 3'b011,
        FN_OR   = 3'b100,
        FN_SLT  = 3'b101,
        FN_RSVD = 3'b110,
        FN_MUL  = 3'b111
    } alu_fn_e;

endpackage

// File: rtl/alu16_arith.sv
// Module : alu16_arith
// Purpose: two's-complement sum, difference and signed less-than.
// Assumes: WIDTH >= 2. Carry and overflow are not reported.
module alu16_arith #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] sum,
    output logic [WIDTH-1:0] diff,
    output logic             lt_signed
);

    localparam int MSB = WIDTH - 1;

    // Adder and subtractor; the subtractor adds the inverted B plus one.
    always_comb begin
        sum  = a + b;
        diff = a + ~b + WIDTH'(1);
    end

    // Signed compare: operands of unlike sign decide on A's sign bit,
    // operands of like sign decide on the sign of the difference.
    always_comb begin
        if (a[MSB] != b[MSB]) begin
            lt_signed = a[MSB];
        end else begin
            lt_signed = diff[MSB];
        end
    end

    // Guards: undoing the add recovers A, and the compare agrees with a
    // direct signed comparison.
    always_comb begin
        a_r1_add_inverse: assert ((sum - b) == a)
            else $error("a_r1_add_inverse");
        a_r2_sub_inverse: assert ((diff + b) == a)
            else $error("a_r2_sub_inverse");
        a_r5_slt_signed: assert (lt_signed == ($signed(a) < $signed(b)))
            else $error("a_r5_slt_signed");
    end

endmodule

// File: rtl/alu16_mul.sv
// Module : alu16_mul
// Purpose: unsigned IN_W x IN_W multiply built as a shift-and-add array.
// Assumes: the caller passes only the low bytes. The product is 2*IN_W
//          bits wide and cannot overflow.
module alu16_mul #(
    parameter int IN_W = 8
) (
    input  logic [IN_W-1:0]   x,
    input  logic [IN_W-1:0]   y,
    output logic [2*IN_W-1:0] prod
);

    localparam int PROD_W = 2 * IN_W;

    logic [PROD_W-1:0] part [IN_W];
    logic [PROD_W-1:0] acc  [IN_W+1];

    assign acc[0] = '0;

    // One row per multiplier bit: a gated, shifted copy of x is added in.
    for (genvar i = 0; i < IN_W; i++) begin : g_row
        assign part[i]  = y[i] ? (PROD_W'(x) << i) : '0;
        assign acc[i+1] = acc[i] + part[i];
    end

    // Final accumulator row is the product.
    assign prod = acc[IN_W];

    // Guard: the array agrees with a behavioural multiply.
    always_comb begin
        a_r6_mul_matches: assert (prod == (PROD_W'(x) * PROD_W'(y)))
            else $error("a_r6_mul_matches");
    end

endmodule

// File: rtl/alu16_shift.sv
// Module : alu16_shift
// Purpose: logical barrel shifter for both directions, one stage per bit of
//          the shift amount. Vacated bits are filled with zero.
// Assumes: 2**AMT_W <= WIDTH.
module alu16_shift #(
    parameter int WIDTH = 16,
    parameter int AMT_W = 3
) (
    input  logic [WIDTH-1:0] din,
    input  logic [AMT_W-1:0] amt,
    input  logic             to_right,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] lstage [AMT_W+1];
    logic [WIDTH-1:0] rstage [AMT_W+1];

    assign lstage[0] = din;
    assign rstage[0] = din;

    // Stage k moves the data by 2**k when bit k of the amount is set.
    for (genvar k = 0; k < AMT_W; k++) begin : g_stage
        assign lstage[k+1] = amt[k] ? (lstage[k] << (1 << k)) : lstage[k];
        assign rstage[k+1] = amt[k] ? (rstage[k] >> (1 << k)) : rstage[k];
    end

    // Direction select.
    assign dout = to_right ? rstage[AMT_W] : lstage[AMT_W];

    // Guards: a zero amount passes the data through, and vacated bits are
    // zero in both directions.
    always_comb begin
        a_r7_pass_zero_amt: assert ((amt != '0) || (dout == din))
            else $error("a_r7_pass_zero_amt");
        a_r7_left_fill: assert (to_right ||
                ((dout & ~({WIDTH{1'b1}} << amt)) == '0))
            else $error("a_r7_left_fill");
        a_r8_right_fill: assert (!to_right ||
                ((dout & ~({WIDTH{1'b1}} >> amt)) == '0))
            else $error("a_r8_right_fill");
    end

endmodule

// File: rtl/alu16_core.sv
// Module : alu16_core
// Purpose: top of the combinational ALU. It selects among the arithmetic,
//          logic, multiply and shift results and derives the zero flag.
// Assumes: the shift controls override the function code. Unused codes
//          give zero. No registers, so no clock or reset.
module alu16_core #(
    parameter int DATA_W  = 16,
    parameter int MUL_W   = 8,
    parameter int SHAMT_W = 3
) (
    input  logic [DATA_W-1:0]  opnd_a,
    input  logic [DATA_W-1:0]  opnd_b,
    input  logic [2:0]         func_code,
    input  logic               shift_en,
    input  logic               shift_right,
    input  logic [SHAMT_W-1:0] shift_amt,
    output logic [DATA_W-1:0]  result,
    output logic               zero_flag
);
    import alu16_pkg::*;

    localparam int PROD_W = 2 * MUL_W;

    logic [DATA_W-1:0] sum_w;
    logic [DATA_W-1:0] diff_w;
    logic              lt_w;
    logic [PROD_W-1:0] prod_w;
    logic [DATA_W-1:0] shift_w;
    logic [DATA_W-1:0] fn_res;
    alu_fn_e           fn;

    assign fn = alu_fn_e'(func_code);

    alu16_arith #(.WIDTH(DATA_W)) u_arith (
        .a         (opnd_a),
        .b         (opnd_b),
        .sum       (sum_w),
        .diff      (diff_w),
        .lt_signed (lt_w)
    );

    alu16_mul #(.IN_W(MUL_W)) u_mul (
        .x    (opnd_a[MUL_W-1:0]),
        .y    (opnd_b[MUL_W-1:0]),
        .prod (prod_w)
    );

    alu16_shift #(.WIDTH(DATA_W), .AMT_W(SHAMT_W)) u_shift (
        .din      (opnd_b),
        .amt      (shift_amt),
        .to_right (shift_right),
        .dout     (shift_w)
    );

    // Function-code select among the non-shift results.
    always_comb begin
        case (fn)
            FN_ADD:  fn_res = sum_w;
            FN_SUB:  fn_res = diff_w;
            FN_AND:  fn_res = opnd_a & opnd_b;
            FN_OR:   fn_res = opnd_a | opnd_b;
            FN_SLT:  fn_res = DATA_W'(lt_w);
            FN_MUL:  fn_res = DATA_W'(prod_w);
            default: fn_res = '0;
        endcase
    end

    // The shift controls take priority over the function code.
    assign result    = shift_en ? shift_w : fn_res;
    assign zero_flag = (result == '0);

    // Guards: unused codes give zero, shift mode follows the shifter, and
    // the compare result is 0 or 1.
    always_comb begin
        a_r10_unused_zero: assert (shift_en ||
                !((func_code == 3'b000) || (func_code == 3'b110)) ||
                (result == '0))
            else $error("a_r10_unused_zero");
        a_r9_shift_priority: assert (!shift_en || (result == shift_w))
            else $error("a_r9_shift_priority");
        a_r5_slt_range: assert (shift_en || (func_code != 3'b101) ||
                (result <= DATA_W'(1)))
            else $error("a_r5_slt_range");
        a_r11_zero_flag: assert (zero_flag == ($countones(result) == 0))
            else $error("a_r11_zero_flag");
    end

endmodule

// File: tb/alu16_core_bench.sv
// Scoreboard bench: the driver applies a vector and queues its expected
// value. The monitor pops and compares at the falling edge after the vector.
module alu16_core_bench;

    localparam int  DW       = 16;
    localparam time HALF     = 2.5ns;
    localparam int  WATCHDOG = 200000;

    typedef struct {
        logic [DW-1:0] res;
        logic          zf;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic [DW-1:0] opnd_a = '0;
    logic [DW-1:0] opnd_b = '0;
    logic [2:0]    func_code = 3'b000;
    logic          shift_en = 1'b0;
    logic          shift_right = 1'b0;
    logic [2:0]    shift_amt = 3'd0;
    logic [DW-1:0] result;
    logic          zero_flag;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_errors = 0;
    bit   all_done = 1'b0;
    bit   summary_done = 1'b0;

    always #HALF clk = ~clk;

    alu16_core u_alu16_core (
        .opnd_a      (opnd_a),
        .opnd_b      (opnd_b),
        .func_code   (func_code),
        .shift_en    (shift_en),
        .shift_right (shift_right),
        .shift_amt   (shift_amt),
        .result      (result),
        .zero_flag   (zero_flag)
    );

    // Reference model, written from the requirements.
    function automatic logic [DW-1:0] ref_model(
        input logic [DW-1:0] a, input logic [DW-1:0] b, input logic [2:0] fc,
        input logic se, input logic sr, input logic [2:0] amt);
        logic [DW-1:0] r;
        if (se) begin
            r = sr ? (b >> amt) : (b << amt);               // R7 R8 R9
        end else begin
            case (fc)
                3'b001: r = a + b;                          // R1
                3'b011: r = a - b;                          // R2
                3'b010: r = a & b;                          // R3
                3'b100: r = a | b;                          // R4
                3'b101: r = ($signed(a) < $signed(b)) ? 16'd1 : 16'd0; // R5
                3'b111: r = {8'd0, a[7:0]} * {8'd0, b[7:0]}; // R6
                default: r = '0;                            // R10
            endcase
        end
        return r;
    endfunction

    task automatic apply(input logic [DW-1:0] a, input logic [DW-1:0] b,
                         input logic [2:0] fc, input logic se, input logic sr,
                         input logic [2:0] amt, input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        opnd_a = a; opnd_b = b; func_code = fc;
        shift_en = se; shift_right = sr; shift_amt = amt;
        e.res = ref_model(a, b, fc, se, sr, amt);
        e.zf  = (e.res == '0);                              // R11
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compare the result and the zero flag at each falling edge.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_checks++;
            if (result !== e.res) begin
                n_errors++;
                $display("FAIL %s result: actual=%h expected=%h", e.tag, result, e.res);
            end
            n_checks++;
            if (zero_flag !== e.zf) begin
                n_errors++;
                $display("FAIL R11 zero flag (%s): actual=%b expected=%b", e.tag, zero_flag, e.zf);
            end
        end
    end

    task automatic finish_up();
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!all_done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            finish_up();
        end
    end

    // Stimulus.
    initial begin
        // Quiescent inputs: zero result, flag high (R10, R11).
        apply(16'h0000, 16'h0000, 3'b000, 1'b0, 1'b0, 3'd0, "R10 idle");
        // R1 add, including wrap to zero.
        apply(16'h1234, 16'h0F0F, 3'b001, 1'b0, 1'b0, 3'd0, "R1");
        apply(16'hFFFF, 16'h0001, 3'b001, 1'b0, 1'b0, 3'd0, "R1 wrap");
        // R2 subtract, negative and equal operands.
        apply(16'h0005, 16'h0007, 3'b011, 1'b0, 1'b0, 3'd0, "R2 neg");
        apply(16'hABCD, 16'hABCD, 3'b011, 1'b0, 1'b0, 3'd0, "R2 equal");
        // R3 and, R4 or.
        apply(16'hF0F0, 16'h3C3C, 3'b010, 1'b0, 1'b0, 3'd0, "R3");
        apply(16'h00FF, 16'hFF00, 3'b010, 1'b0, 1'b0, 3'd0, "R3 disjoint");
        apply(16'hF000, 16'h000F, 3'b100, 1'b0, 1'b0, 3'd0, "R4");
        // R5 signed compare across the sign bit.
        apply(16'hFFFF, 16'h0001, 3'b101, 1'b0, 1'b0, 3'd0, "R5 neg<pos");
        apply(16'h0001, 16'hFFFF, 3'b101, 1'b0, 1'b0, 3'd0, "R5 pos>neg");
        apply(16'h8000, 16'h7FFF, 3'b101, 1'b0, 1'b0, 3'd0, "R5 extremes");
        apply(16'h0042, 16'h0042, 3'b101, 1'b0, 1'b0, 3'd0, "R5 equal");
        // R6 multiply: largest product, upper bytes ignored, zero operand.
        apply(16'h00FF, 16'h00FF, 3'b111, 1'b0, 1'b0, 3'd0, "R6 max");
        apply(16'h12FF, 16'hAB02, 3'b111, 1'b0, 1'b0, 3'd0, "R6 upper bytes");
        apply(16'hFF00, 16'h00FF, 3'b111, 1'b0, 1'b0, 3'd0, "R6 zero byte");
        // R7 left and R8 right over every shift amount, with A varied.
        for (int s = 0; s < 8; s++) begin
            apply(16'(s * 16'h1111), 16'h8001, 3'b000, 1'b1, 1'b0, 3'(s), "R7");
            apply(16'(s * 16'h2222), 16'h8001, 3'b000, 1'b1, 1'b1, 3'(s), "R8");
        end
        // R9 shift overrides an active function code.
        apply(16'h00FF, 16'h00F0, 3'b111, 1'b1, 1'b0, 3'd4, "R9 over mul");
        apply(16'h0003, 16'h0100, 3'b001, 1'b1, 1'b1, 3'd7, "R9 over add");
        // R10 unused codes with non-zero operands.
        apply(16'hBEEF, 16'hCAFE, 3'b000, 1'b0, 1'b0, 3'd5, "R10 code0");
        apply(16'hBEEF, 16'hCAFE, 3'b110, 1'b0, 1'b1, 3'd2, "R10 code6");
        // Random mix covering every requirement.
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r0, r1, r2;
            r0 = $urandom();
            r1 = $urandom();
            r2 = $urandom();
            apply(r0[15:0], r1[15:0], r2[2:0], r2[3] & r2[4], r2[5], r2[8:6],
                  "R1-R11 random");
        end
        repeat (3) @(posedge clk);
        all_done = 1'b1;
        finish_up();
    end

endmodule